// File: doc/BRIEF.md
# Timer Count-Clock Source Selector

This block decides, cycle by cycle, whether a general-purpose timer counts. It produces a single-cycle count enable (`tick_o`) in the timer clock domain. Four kinds of source can drive it: the timer clock itself, where every cycle counts; the edges of an asynchronous input pin; the rising edges of an asynchronous external trigger; and the trigger pulses of a companion timer, which then acts as a prescaler. A 3-bit mode field picks among the internal clock, the pin and the companion timer. A separate bit sends rising edges of the external trigger to the counter, and that bit takes priority over the mode field.

The block also holds the run, direction and edge-polarity controls, plus an update-request bit that clears itself. A small write port loads these bits. A minimal wrap-around up/down counter sits behind the tick so that the selected source has a visible effect. That counter pulses `upd_o` when it wraps, and also when software requests an update.

Top module: `tmr_clksel`

## Requirements
- R1: After reset, `count_o` is 0 and `tick_o`, `upd_o` and `ug_o` are 0. All control bits are 0, so the mode is 000 and the counter is stopped.
- R2: The control register is written with `wr_en`=1 and `wr_addr`=0. Its fields are:
  - `wr_data[0]`: run
  - `wr_data[1]`: direction (1 = down)
  - `wr_data[2]`: pin polarity (1 = falling edges)
  - `wr_data[3]`: external-trigger select
  - `wr_data[6:4]`: mode

  The new value takes effect in the cycle after the write edge.
- R3: With run=1, trigger select=0 and mode 000, `tick_o` is 1 in every cycle.
- R4: In mode 111 with polarity 0, each rising edge of `pin_i` gives exactly one `tick_o` cycle. If `pin_i` changes before clock edge e0, the tick appears in the cycle that follows edge e0+1.
- R5: In mode 111 with polarity 1, each falling edge of `pin_i` gives one tick with the same latency as R4, and rising edges give none.
- R6: With trigger select=1, each rising edge of `trig_i` gives one tick with the latency of R4, whatever the mode field holds.
- R7: In mode 001, `tick_o` follows `itr_i` in the same cycle, so each single-cycle companion pulse gives one tick.
- R8: Mode values other than 000, 001 and 111 give no tick when trigger select=0.
- R9: With run=0, no source gives a tick and `count_o` holds its value.
- R10: On each tick, direction 0 steps the count up from `CNT_TOP` to 0 and direction 1 steps it down from 0 to `CNT_TOP`. `upd_o` is 1 in a tick cycle whose step wraps.
- R11: A write to `wr_addr`=1 with `wr_data[0]`=1 sets `ug_o` for exactly the next cycle, and `upd_o` is 1 in that cycle. At the end of that cycle the count reloads: to 0 when counting up, to `CNT_TOP` when counting down. This reload wins over a tick in the same cycle. After that, `ug_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = update request |
| wr_data | input | 8 | Write data |
| pin_i | input | 1 | Asynchronous timer input pin |
| trig_i | input | 1 | Asynchronous external trigger |
| itr_i | input | 1 | Companion timer trigger, synchronous single-cycle pulses |
| tick_o | output | 1 | Count enable for this cycle |
| upd_o | output | 1 | Update pulse (wrap or software request) |
| ug_o | output | 1 | Update-request bit readback |
| count_o | output | CNT_W | Counter value |

## Verification
The hardest case to reach from the ports is an update request that lands in the same cycle as a tick from a source other than the free-running clock. In that case the reload must beat the step, and `upd_o` must not pulse twice. The source might be a synchronized pin edge two stages deep, or a companion pulse. Random stimulus keeps the pin, trigger and companion inputs toggling while it rewrites the mode, polarity and direction at random. It also fires update requests often enough that many of them coincide with ticks and with wrap points near the small default `CNT_TOP`. Directed phases first reach each source alone.

// File: rtl/tmr_clksel_pkg.sv
package tmr_clksel_pkg;

    localparam int DATA_W = 8;

    localparam logic [2:0] MODE_INTERNAL  = 3'b000;
    localparam logic [2:0] MODE_COMPANION = 3'b001;
    localparam logic [2:0] MODE_PIN       = 3'b111;

    // field order matches wr_data[6:0]
    typedef struct packed {
        logic [2:0] mode;
        logic       xtrg;
        logic       pol;
        logic       dir;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t ctrl;
        logic  ug;
    } regs_t;

endpackage

// File: rtl/tcs_edge_det.sv
module tcs_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o =  sh_q[SH_W-2] & ~sh_q[SH_W-1];
    assign fall_o = ~sh_q[SH_W-2] &  sh_q[SH_W-1];
endmodule

// File: rtl/tcs_counter.sv
module tcs_counter #(
    parameter int CNT_W   = 8,
    parameter int CNT_TOP = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             dir_i,
    input  logic             load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_TOP);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    always_comb begin
        at_end = dir_i ? (cnt_q == '0) : (cnt_q == TOP);
        wrap_o = tick_i & at_end;
        cnt_d  = cnt_q;
        if (load_i) begin
            cnt_d = dir_i ? TOP : '0;
        end else if (tick_i) begin
            if (dir_i) cnt_d = at_end ? TOP : cnt_q - ONE;
            else       cnt_d = at_end ? '0  : cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/tmr_clksel.sv
module tmr_clksel
    import tmr_clksel_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int CNT_TOP     = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pin_i,
    input  logic              trig_i,
    input  logic              itr_i,
    output logic              tick_o,
    output logic              upd_o,
    output logic              ug_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam int N_EXT   = 2;
    localparam int IDX_PIN = 0;
    localparam int IDX_TRG = 1;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d    = regs_q;
        regs_d.ug = 1'b0;
        if (wr_en) begin
            if (!wr_addr) regs_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
            else          regs_d.ug   = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    logic [N_EXT-1:0] ext_in, ext_rise, ext_fall;
    assign ext_in = {trig_i, pin_i};

    for (genvar g = 0; g < N_EXT; g++) begin : g_sync
        tcs_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (ext_in[g]),
            .rise_o (ext_rise[g]),
            .fall_o (ext_fall[g])
        );
    end

    logic src_evt;
    logic wrap;

    always_comb begin
        if (regs_q.ctrl.xtrg) begin
            src_evt = ext_rise[IDX_TRG];
        end else begin
            case (regs_q.ctrl.mode)
                MODE_INTERNAL:  src_evt = 1'b1;
                MODE_COMPANION: src_evt = itr_i;
                MODE_PIN:       src_evt = regs_q.ctrl.pol ? ext_fall[IDX_PIN]
                                                          : ext_rise[IDX_PIN];
                default:        src_evt = 1'b0;
            endcase
        end
    end

    assign tick_o = regs_q.ctrl.en & src_evt;

    tcs_counter #(.CNT_W(CNT_W), .CNT_TOP(CNT_TOP)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_o),
        .dir_i   (regs_q.ctrl.dir),
        .load_i  (regs_q.ug),
        .count_o (count_o),
        .wrap_o  (wrap)
    );

    // a wrap that coincides with a reload is the same update event
    assign upd_o = regs_q.ug | wrap;
    assign ug_o  = regs_q.ug;
endmodule

// File: rtl/tmr_clksel_chk.sv
module tmr_clksel_chk #(
    parameter int CNT_W   = 8,
    parameter int CNT_TOP = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             tick_o,
    input  logic             upd_o,
    input  logic             ug_o,
    input  logic [CNT_W-1:0] count_o,
    input  logic             en,
    input  logic             dir,
    input  logic             xtrg,
    input  logic [2:0]       mode
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_TOP);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R9
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick_o);

    // R9
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && !ug_o) |=> $stable(count_o));

    // R3
    internal_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !xtrg && mode == 3'b000) |-> tick_o);

    // R11
    ug_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ug_o && !(wr_en && wr_addr && wr_data[0])) |=> !ug_o);

    // R11
    ug_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ug_o |-> upd_o);

    // R11
    ug_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ug_o |=> (count_o == ($past(dir) ? TOP : '0)));

    // R10
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !ug_o && !dir && count_o != TOP) |=> count_o == $past(count_o) + ONE);

    // R10
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !dir && count_o == TOP) |-> upd_o);
endmodule

bind tmr_clksel tmr_clksel_chk #(.CNT_W(CNT_W), .CNT_TOP(CNT_TOP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tick_o  (tick_o),
    .upd_o   (upd_o),
    .ug_o    (ug_o),
    .count_o (count_o),
    .en      (regs_q.ctrl.en),
    .dir     (regs_q.ctrl.dir),
    .xtrg    (regs_q.ctrl.xtrg),
    .mode    (regs_q.ctrl.mode)
);

// File: tb/tmr_clksel_tb.sv
module tmr_clksel_tb;
    localparam int CNT_W   = 8;
    localparam int CNT_TOP = 19;
    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_TOP);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_addr = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             pin_i = 1'b0;
    logic             trig_i = 1'b0;
    logic             itr_i = 1'b0;
    logic             tick_o, upd_o, ug_o;
    logic [CNT_W-1:0] count_o;

    int n_vec = 0;
    int n_err = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_clksel #(.CNT_W(CNT_W), .CNT_TOP(CNT_TOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_i(pin_i), .trig_i(trig_i), .itr_i(itr_i),
        .tick_o(tick_o), .upd_o(upd_o), .ug_o(ug_o), .count_o(count_o)
    );

    // model built from the requirement text
    logic m_en, m_dir, m_pol, m_xtrg, m_ug;
    logic [2:0] m_mode;
    logic [2:0] m_pin, m_trg;
    logic [CNT_W-1:0] m_cnt;

    function automatic logic m_tick();
        logic pr, pf, tr;
        pr = m_pin[1] & ~m_pin[2];
        pf = ~m_pin[1] & m_pin[2];
        tr = m_trg[1] & ~m_trg[2];
        if (!m_en)  return 1'b0;          // R9
        if (m_xtrg) return tr;            // R6
        case (m_mode)
            3'b000:  return 1'b1;         // R3
            3'b001:  return itr_i;        // R7
            3'b111:  return m_pol ? pf : pr; // R4 R5
            default: return 1'b0;         // R8
        endcase
    endfunction

    function automatic logic m_wrap();
        return m_tick() & (m_dir ? (m_cnt == '0) : (m_cnt == TOP));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_en, m_dir, m_pol, m_xtrg, m_ug} = '0;
            m_mode = '0; m_pin = '0; m_trg = '0; m_cnt = '0;
        end else begin
            if (m_ug)          m_cnt = m_dir ? TOP : '0;
            else if (m_tick()) begin
                if (m_dir) m_cnt = (m_cnt == '0) ? TOP : m_cnt - 1'b1;
                else       m_cnt = (m_cnt == TOP) ? '0 : m_cnt + 1'b1;
            end
            m_ug  = wr_en && wr_addr && wr_data[0];
            if (wr_en && !wr_addr) begin
                m_en = wr_data[0]; m_dir = wr_data[1]; m_pol = wr_data[2];
                m_xtrg = wr_data[3]; m_mode = wr_data[6:4];
            end
            m_pin = {m_pin[1:0], pin_i};
            m_trg = {m_trg[1:0], trig_i};
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, between the falling edge drive and the next rising edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("tick_o",  32'(tick_o),  32'(m_tick()));
            chk("upd_o",   32'(upd_o),   32'(m_ug | m_wrap()));
            chk("ug_o",    32'(ug_o),    32'(m_ug));
            chk("count_o", 32'(count_o), 32'(m_cnt));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic toggle(inout logic s, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); s = ~s;
            cyc(gap);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        cyc(3);
        #2;
        // R1 reset state, checked explicitly
        tag = "R1";
        chk("count_o", 32'(count_o), 0);
        chk("tick_o",  32'(tick_o),  0);
        chk("ug_o",    32'(ug_o),    0);
        chk("upd_o",   32'(upd_o),   0);
        @(negedge clk); rst_n = 1'b1;
        cyc(4);

        tag = "R2 R3";   wr(0, 8'h01); cyc(25);          // run, internal clock, through a wrap
        tag = "R11";     wr(1, 8'h01); cyc(3);
        #2; chk("ug_o cleared", 32'(ug_o), 0);
        tag = "R9";      wr(0, 8'h70); toggle(pin_i, 6, 3); toggle(trig_i, 6, 3); cyc(3);
        tag = "R4";      wr(0, 8'h71); toggle(pin_i, 10, 2); cyc(4);
        tag = "R5";      wr(0, 8'h75); toggle(pin_i, 10, 1); cyc(4);
        tag = "R6";      wr(0, 8'h79); toggle(trig_i, 10, 2); toggle(pin_i, 4, 2); cyc(4);
        tag = "R7";      wr(0, 8'h11);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); itr_i = 1'b1; @(negedge clk); itr_i = 1'b0; cyc(2);
        end
        tag = "R8";      wr(0, 8'h21); toggle(pin_i, 4, 1); wr(0, 8'h41); toggle(itr_i, 4, 1); cyc(2);
        tag = "R10";     wr(0, 8'h03); cyc(30);
        tag = "R11 down"; wr(1, 8'h01); cyc(3);

        tag = "R10 R11 random";
        void'($urandom(32'h1D5E_0A7C));
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if ($urandom_range(0, 99) < 30) pin_i  = ~pin_i;
            if ($urandom_range(0, 99) < 30) trig_i = ~trig_i;
            itr_i = ($urandom_range(0, 99) < 25);
            if ($urandom_range(0, 99) < 6) begin
                logic [2:0] md;
                case ($urandom_range(0, 4))
                    0: md = 3'b000;
                    1: md = 3'b001;
                    2: md = 3'b111;
                    3: md = 3'b111;
                    default: md = 3'($urandom_range(0, 7));
                endcase
                wr_en = 1'b1; wr_addr = 1'b0;
                wr_data = {1'b0, md, 1'($urandom_range(0, 3) == 0), 1'($urandom),
                           1'($urandom), 1'($urandom_range(0, 5) != 0)};
            end else if ($urandom_range(0, 99) < 5) begin
                wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'($urandom);
            end
        end
        @(negedge clk); wr_en = 1'b0;
        cyc(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule